// File: doc/BRIEF.md
# Pin bank with edge-event interrupts

A bank of 32 general-purpose pins controlled through a small 32-bit register bus. Each pin can be set as an input or an output. An output pin can drive both levels or run open-drain, where it only pulls low. The bank samples its inputs through a synchroniser. It records edges on them in sticky event bits, and it raises one combined interrupt line while any enabled event is pending.

Software sets the pin directions, the drive style and the output levels. It then picks, pin by pin, whether falling edges alone or edges in either direction count as events. It unmasks the pins it cares about, services the interrupt, and clears the events it has handled by writing ones to them. Pins are numbered from the most significant end: pin n is bit 31 − n in every per-pin register. On the pin-side ports, bit n is pin n.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register reads 0. Every pin is an input with its output enable low, no event is pending, and the interrupt line is low.
- R2: Registers are selected by byte address: 0x00 direction, 0x04 open-drain select, 0x08 data, 0x0C event, 0x10 mask, 0x14 edge control. A write takes effect on the clock edge where bus_sel and bus_wr are both high. Read data is combinational from bus_addr. Any other address reads 0, and writes to it change nothing.
- R3: Pin n (port bit n of pin_in, pin_out and pin_oe) corresponds to bit 31 − n of every per-pin register.
- R4: A direction bit of 1 makes the pin an output and a 0 makes it an input. An input has pin_oe low. An output without open-drain has pin_oe high and pin_out equal to its data bit.
- R5: An output whose open-drain bit is 1 has pin_out 0. Its pin_oe is high only while its data bit is 0.
- R6: Reading the data register returns the stored data bit for outputs. For inputs it returns the pin level two clock edges after it was applied.
- R7: An edge-control bit of 1 records only falling (1 to 0) edges on that pin. A 0 records both rising and falling edges.
- R8: Event bits are sticky. Writing 1 to an event bit clears it, and writing 0 leaves it unchanged.
- R9: If an edge is detected on the same clock edge as a write of 1 to that pin's event bit, the bit remains set.
- R10: irq is high exactly when some event bit and its mask bit are both 1. A mask bit of 0 blocks that pin.
- R11: A pin change applied before clock edge k sets its event bit, and so irq, on clock edge k+2. It is invisible after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| pin_in | input | DATA_W | Pin levels from the pads, bit n is pin n |
| pin_out | output | DATA_W | Level driven to the pads, bit n is pin n |
| pin_oe | output | DATA_W | Pad output enable, bit n is pin n |
| irq | output | 1 | Combined interrupt, high while an unmasked event is pending |

## Verification
The bench targets the reversed bit order: a design that numbered pins from bit 0 would drive and report the wrong pin. It targets the falling-only mode with a rising edge on a falling-only pin, which a design that ignored the control bit would record. It also lands an edge on the same cycle as its own clear. A design that let the clear win would lose that event and leave irq low. The bench also checks the exact event latency through the synchroniser, and that a write of zeros to the event register leaves pending events alone. A behavioural model checks every cycle of a long random stretch of pin activity and register writes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int PIN_COUNT = 32;

   typedef enum logic [4:0] {
      REG_DIR   = 5'h00,
      REG_ODSEL = 5'h04,
      REG_DATA  = 5'h08,
      REG_EVENT = 5'h0C,
      REG_MASK  = 5'h10,
      REG_EDGE  = 5'h14
   } reg_sel_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_edge_events.sv
module gpio_edge_events #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level,
   input  logic [W-1:0] fall_only,
   input  logic [W-1:0] clr,
   output logic [W-1:0] hit,
   output logic [W-1:0] evt
);

   logic [W-1:0] level_d;
   logic [W-1:0] rise;
   logic [W-1:0] fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= '0;
      else        level_d <= level;
   end

   assign rise = level & ~level_d;
   assign fall = ~level & level_d;

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         assign hit[b] = fall_only[b] ? fall[b] : (rise[b] | fall[b]);
      end
   endgenerate

   // a fresh edge wins over a clear landing on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt <= '0;
      else        evt <= (evt & ~clr) | hit;
   end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
   parameter int W = 32
) (
   input  logic [W-1:0] dir,
   input  logic [W-1:0] od,
   input  logic [W-1:0] data,
   output logic [W-1:0] drv_out,
   output logic [W-1:0] drv_oe
);

   generate
      for (genvar b = 0; b < W; b++) begin : g_pad
         always_comb begin
            if (!dir[b]) begin
               drv_out[b] = 1'b0;
               drv_oe[b]  = 1'b0;
            end else if (od[b]) begin
               drv_out[b] = 1'b0;
               drv_oe[b]  = ~data[b];
            end else begin
               drv_out[b] = data[b];
               drv_oe[b]  = 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_bank_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] pin_out,
   output logic [DATA_W-1:0] pin_oe,
   output logic              irq
);

   localparam int TOP_BIT = DATA_W - 1;

   generate
      if (DATA_W != PIN_COUNT) begin : g_bad_width
         $error("gpio_edge_bank: DATA_W must equal the pin count");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("gpio_edge_bank: ADDR_W too narrow for the register map");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_edge_bank: at least two synchroniser stages required");
      end
   endgenerate

   logic [DATA_W-1:0] dir_q, od_q, data_q, mask_q, edge_q;
   logic [DATA_W-1:0] in_rd, sync_rd, evt_q, evt_hit, evt_clr;
   logic [DATA_W-1:0] drv_out, drv_oe;
   logic              wr_go;
   logic              we_dir, we_od, we_data, we_event, we_mask, we_edge;

   // pin n <-> register bit TOP_BIT-n
   generate
      for (genvar n = 0; n < DATA_W; n++) begin : g_map
         assign in_rd[TOP_BIT-n] = pin_in[n];
         assign pin_out[n]       = drv_out[TOP_BIT-n];
         assign pin_oe[n]        = drv_oe[TOP_BIT-n];
      end
   endgenerate

   assign wr_go    = bus_sel & bus_wr;
   assign we_dir   = wr_go & (bus_addr == ADDR_W'(REG_DIR));
   assign we_od    = wr_go & (bus_addr == ADDR_W'(REG_ODSEL));
   assign we_data  = wr_go & (bus_addr == ADDR_W'(REG_DATA));
   assign we_event = wr_go & (bus_addr == ADDR_W'(REG_EVENT));
   assign we_mask  = wr_go & (bus_addr == ADDR_W'(REG_MASK));
   assign we_edge  = wr_go & (bus_addr == ADDR_W'(REG_EDGE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         od_q   <= '0;
         data_q <= '0;
         mask_q <= '0;
         edge_q <= '0;
      end else begin
         if (we_dir)  dir_q  <= bus_wdata;
         if (we_od)   od_q   <= bus_wdata;
         if (we_data) data_q <= bus_wdata;
         if (we_mask) mask_q <= bus_wdata;
         if (we_edge) edge_q <= bus_wdata;
      end
   end

   assign evt_clr = we_event ? bus_wdata : '0;

   gpio_pin_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (in_rd),
      .sync_out (sync_rd)
   );

   gpio_edge_events #(.W(DATA_W)) i_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .level     (sync_rd),
      .fall_only (edge_q),
      .clr       (evt_clr),
      .hit       (evt_hit),
      .evt       (evt_q)
   );

   gpio_pad_drive #(.W(DATA_W)) i_pads (
      .dir     (dir_q),
      .od      (od_q),
      .data    (data_q),
      .drv_out (drv_out),
      .drv_oe  (drv_oe)
   );

   always_comb begin
      if (bus_addr == ADDR_W'(REG_DIR))        bus_rdata = dir_q;
      else if (bus_addr == ADDR_W'(REG_ODSEL)) bus_rdata = od_q;
      else if (bus_addr == ADDR_W'(REG_DATA))  bus_rdata = (dir_q & data_q) | (~dir_q & sync_rd);
      else if (bus_addr == ADDR_W'(REG_EVENT)) bus_rdata = evt_q;
      else if (bus_addr == ADDR_W'(REG_MASK))  bus_rdata = mask_q;
      else if (bus_addr == ADDR_W'(REG_EDGE))  bus_rdata = edge_q;
      else                                     bus_rdata = '0;
   end

   assign irq = |(evt_q & mask_q);

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_event,
   input logic [W-1:0] wdata,
   input logic [W-1:0] evt,
   input logic [W-1:0] hit,
   input logic [W-1:0] dir,
   input logic [W-1:0] od,
   input logic [W-1:0] data,
   input logic [W-1:0] drv_out,
   input logic [W-1:0] drv_oe
);

   AST_EVT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_event |=> ((evt & $past(wdata & ~hit)) == '0)); // R8

   AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_event |=> (($past(evt) & ~evt) == '0)); // R8

   AST_HIT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((evt & $past(hit)) == $past(hit))); // R9

   AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      ((drv_oe & ~dir) == '0)); // R4

   AST_PUSH_PULL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      ((dir & ~od & (drv_out ^ data)) == '0)); // R4

   AST_OD_NO_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ((dir & od & data & drv_oe) == '0)); // R5

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.W(DATA_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_event (we_event),
   .wdata    (bus_wdata),
   .evt      (evt_q),
   .hit      (evt_hit),
   .dir      (dir_q),
   .od       (od_q),
   .data     (data_q),
   .drv_out  (drv_out),
   .drv_oe   (drv_oe)
);

// File: tb/test_gpio_edge_bank.sv
`timescale 1ns/1ps
module test_gpio_edge_bank;

   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic [W-1:0]  bus_wdata = '0;
   logic [W-1:0]  bus_rdata;
   logic [W-1:0]  pin_in = '0;
   logic [W-1:0]  pin_out;
   logic [W-1:0]  pin_oe;
   logic          irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   gpio_edge_bank i_gpio_edge_bank (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [W-1:0] m_s1, m_s2, m_prev;            // pin-numbered history
   logic [W-1:0] m_dir, m_od, m_data, m_evt, m_mask, m_edge;  // register order

   function automatic logic [W-1:0] flip(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[W-1-i] = v[i];
      return r;
   endfunction

   function automatic logic [W-1:0] m_read(input logic [4:0] a);
      case (a)
         5'h00: return m_dir;
         5'h04: return m_od;
         5'h08: return (m_dir & m_data) | (~m_dir & flip(m_s2));
         5'h0C: return m_evt;
         5'h10: return m_mask;
         5'h14: return m_edge;
         default: return '0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0;
         m_dir = '0; m_od = '0; m_data = '0; m_evt = '0; m_mask = '0; m_edge = '0;
      end else begin
         logic [W-1:0] now_r, was_r, newhit, clr;
         now_r  = flip(m_s2);
         was_r  = flip(m_prev);
         newhit = '0;
         for (int b = 0; b < W; b++) begin
            if (now_r[b] != was_r[b]) begin
               if (!m_edge[b] || (was_r[b] && !now_r[b])) newhit[b] = 1'b1;
            end
         end
         clr = (bus_sel && bus_wr && bus_addr == 5'h0C) ? bus_wdata : '0;
         m_evt  = (m_evt & ~clr) | newhit;
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = pin_in;
         if (bus_sel && bus_wr) begin
            case (bus_addr)
               5'h00: m_dir  = bus_wdata;
               5'h04: m_od   = bus_wdata;
               5'h08: m_data = bus_wdata;
               5'h10: m_mask = bus_wdata;
               5'h14: m_edge = bus_wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison, 1 ns after each rising edge
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk("R2/R6 model rdata", bus_rdata, m_read(bus_addr));
         chk("R3/R4/R5 model pin_out", pin_out, flip(m_dir & m_data & ~m_od));
         chk("R3/R4/R5 model pin_oe", pin_oe, flip(m_dir & (~m_od | ~m_data)));
         chk("R10 model irq", {31'b0, irq}, {31'b0, |(m_evt & m_mask)});
      end
   end

   // ---------------- bus tasks ----------------
   task automatic bus_write(input logic [4:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic read_expect(input logic [4:0] a, input logic [W-1:0] exp, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(posedge clk); #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // ---------------- directed and random stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 pin_oe after reset", pin_oe, '0);
      chk("R1 irq after reset", {31'b0, irq}, '0);
      for (int a = 0; a < 8; a++) read_expect(5'(a * 4), '0, "R1 register after reset");

      // R3/R4: pins 0 and 31 outputs, pin 0 high
      bus_write(5'h00, 32'h8000_0001);
      bus_write(5'h08, 32'h8000_0000);
      chk("R3 pin_out pin0 high", pin_out, 32'h0000_0001);
      chk("R4 pin_oe pins 0 and 31", pin_oe, 32'h8000_0001);

      // R5 open drain on pin 31
      bus_write(5'h04, 32'h0000_0001);
      chk("R5 od low drives", pin_oe, 32'h8000_0001);
      bus_write(5'h08, 32'h8000_0001);
      chk("R5 od high released", pin_oe, 32'h0000_0001);
      chk("R5 od pin_out zero", pin_out, 32'h0000_0001);

      // R6 data read-back: pin 1 input goes high, pin 0 output pad low
      @(negedge clk); pin_in[1] = 1'b1; pin_in[0] = 1'b0;
      idle(3);
      read_expect(5'h08, 32'hC000_0001, "R6 data read mixed");

      // clear, pins 16..31 falling only, unmask all
      bus_write(5'h0C, 32'hFFFF_FFFF);
      bus_write(5'h14, 32'h0000_FFFF);
      bus_write(5'h10, 32'hFFFF_FFFF);
      read_expect(5'h0C, 32'h0000_0000, "R8 all events cleared");

      // R11 latency on pin 2 (bit 29, both edges)
      @(negedge clk); bus_sel = 1'b0; pin_in[2] = 1'b1;
      @(posedge clk); #1;
      @(posedge clk); #1;
      chk("R11 irq low after two edges", {31'b0, irq}, '0);
      @(posedge clk); #1;
      chk("R11 irq high after third edge", {31'b0, irq}, 32'h1);
      read_expect(5'h0C, 32'h2000_0000, "R7 both-edge rise recorded");

      // R7 pin 20 (bit 11, falling only)
      @(negedge clk); bus_sel = 1'b0; pin_in[20] = 1'b1;
      idle(4);
      read_expect(5'h0C, 32'h2000_0000, "R7 rise ignored on falling-only pin");
      @(negedge clk); bus_sel = 1'b0; pin_in[20] = 1'b0;
      idle(4);
      read_expect(5'h0C, 32'h2000_0800, "R7 fall recorded");

      // R8 write-one-to-clear
      bus_write(5'h0C, 32'h0000_0000);
      read_expect(5'h0C, 32'h2000_0800, "R8 zero write keeps events");
      bus_write(5'h0C, 32'h2000_0000);
      read_expect(5'h0C, 32'h0000_0800, "R8 one clears only its bit");

      // R10 masking
      bus_write(5'h10, 32'h0000_0000);
      chk("R10 all masked", {31'b0, irq}, '0);
      bus_write(5'h10, 32'h0000_0800);
      chk("R10 matching mask", {31'b0, irq}, 32'h1);
      bus_write(5'h10, 32'hFFFF_F7FF);
      chk("R10 other bits only", {31'b0, irq}, '0);

      // R9 edge coincides with its own clear
      @(negedge clk); bus_sel = 1'b0; pin_in[2] = 1'b0;
      @(negedge clk);
      bus_write(5'h0C, 32'h2000_0800);
      read_expect(5'h0C, 32'h2000_0000, "R9 edge beats clear");
      bus_write(5'h0C, 32'hFFFF_FFFF);
      read_expect(5'h0C, 32'h0000_0000, "R9 later clear works");

      // R2 unmapped addresses
      bus_write(5'h18, 32'hFFFF_FFFF);
      bus_write(5'h1C, 32'hFFFF_FFFF);
      read_expect(5'h18, 32'h0000_0000, "R2 unmapped reads zero");
      read_expect(5'h00, 32'h8000_0001, "R2 direction untouched");
      read_expect(5'h10, 32'hFFFF_F7FF, "R2 mask untouched");

      // random stretch checked against the model every cycle
      for (int c = 0; c < 2000; c++) begin
         @(negedge clk);
         pin_in   = pin_in ^ ($urandom & $urandom & $urandom);
         bus_sel  = ($urandom % 3) != 0;
         bus_wr   = ($urandom % 4) == 0;
         bus_addr = 5'(($urandom % 8) * 4);
         bus_wdata = $urandom;
      end
      idle(4);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule